// File: doc/BRIEF.md
# Multi-engine DMA queue register decoder

This block sits on a simple register write bus (address, data, valid) in front of a bank of DMA queue engines. Every engine owns an address window given by a base and a size. A compile-time variant parameter fixes both the window set and the register map: a two-engine layout and an eight-engine layout. A write that falls in a window is turned into a word index, and that index selects one register of the engine's primary or secondary queue. A write that falls in no window leaves through a fallback port in the same cycle, so that the rest of the device can decode it.

The block holds the queue registers itself: ring base, read pointer, write pointer, doorbell control, doorbell offset and ring size. Any of these can be read back through a combinational read port. The ring-size write carries a log-encoded field, which the block checks and turns into a byte length. A doorbell offset write issues a one-cycle registration pulse, but only when the doorbell enable bit of that queue is set. The pulse tells the doorbell logic which engine and queue now answer to that offset.

Top module: `dma_reg_decoder`

## Requirements
- R1: After reset every stored register reads zero, `rd_len` is zero, `size_err` is 0 and `db_valid` is 0.
- R2: Engine windows are, with `VARIANT`=1, eight windows of 0x1000 bytes based at 0x4980, 0x6180, 0x78000, 0x79000, 0x7A000, 0x7B000, 0x7C000, 0x7D000. With `VARIANT`=0 they are two windows of 0x800 bytes at 0x4980 and 0x5180. The lowest-numbered window containing the address claims the write, and the register index is (address − base) >> 2.
- R3: Primary queue (`rd_queue`=0) indices in both variants: 0x80 size, 0x81 base low, 0x82 base high, 0x89 read pointer low, 0x88 read pointer high, 0xB2 write pointer low, 0xB3 write pointer high, 0x92 doorbell control, 0xAB doorbell offset. Read selector codes: 0 base low, 1 base high, 2 rptr low, 3 rptr high, 4 wptr low, 5 wptr high, 6 doorbell control, 7 doorbell offset, 8 size exponent. Other codes read 0.
- R4: Secondary queue (`rd_queue`=1) indices. With `VARIANT`=0: 0xE1 base low, 0xE9 rptr low, 0xE8 rptr high, 0xF2 doorbell control, 0x10B doorbell offset, 0xE0 size, 0x113 wptr low. With `VARIANT`=1: 0xD9 base low, 0xE1 rptr low, 0xE0 rptr high, 0xEA doorbell control, 0xD8 doorbell offset, 0x10B wptr low.
- R5: A write inside a window whose index is not in the map changes no register, raises no pulse and does not appear on the fallback port.
- R6: A write outside every window drives `fb_valid` high in the same cycle, with `fb_addr` and `fb_data` equal to the write. No register changes.
- R7: A size write takes its field from data bits [6:1]. For a field of 6 to 62, selector code 8 reads field+2 and `rd_len` equals 1 << (field+2).
- R8: A size field outside 6..62 sets `size_err`, which stays set until reset, and the previous size is kept.
- R9: A doorbell offset write, made while bit 28 of that queue's doorbell control register is set, makes `db_valid` high for exactly the cycle after the write. `db_offset` carries the written data, `db_engine` the engine and `db_queue` the queue (0 primary, 1 secondary).
- R10: A doorbell offset write while bit 28 is clear raises no pulse, but still stores the offset.
- R11: A write is taken in the cycle its valid is high. The read port shows the new value only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data |
| fb_valid | output | 1 | Write missed every engine window |
| fb_addr | output | AW | Address forwarded on a miss |
| fb_data | output | 32 | Data forwarded on a miss |
| rd_engine | input | 3 | Engine selected for readback |
| rd_queue | input | 1 | Queue selected for readback (0 primary, 1 secondary) |
| rd_sel | input | 4 | Register selector code |
| rd_data | output | 32 | Readback value |
| rd_len | output | 65 | Ring length in bytes of the selected queue |
| size_err | output | 1 | Sticky illegal ring-size flag |
| db_valid | output | 1 | Doorbell registration pulse |
| db_offset | output | 32 | Registered doorbell offset |
| db_engine | output | 3 | Engine of the registration |
| db_queue | output | 1 | Queue of the registration |

## Verification
The bench builds two copies side by side on one write bus: `u0` with `VARIANT`=1 and `u1` with `VARIANT`=0. The eight-engine copy reaches the far windows and their edges, as well as the secondary map that has no size register. The two-engine copy covers the other secondary map. Because both copies see the same writes, one address shows the variant split directly. 0x5180 is engine 1's window base in one copy and an unmapped index inside engine 0's larger window in the other. Likewise, the secondary size index of one variant lands on a read pointer register in the other.

// File: rtl/dma_reg_decoder.sv
`timescale 1ns/1ps
module dma_reg_decoder #(
  parameter int VARIANT = 1,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic          fb_valid,
  output logic [AW-1:0] fb_addr,
  output logic [31:0]   fb_data,
  input  logic [2:0]    rd_engine,
  input  logic          rd_queue,
  input  logic [3:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic [64:0]   rd_len,
  output logic          size_err,
  output logic          db_valid,
  output logic [31:0]   db_offset,
  output logic [2:0]    db_engine,
  output logic          db_queue
);
  localparam int NE = (VARIANT != 0) ? 8 : 2;
  localparam logic [31:0] WIN = (VARIANT != 0) ? 32'h1000 : 32'h800;
  localparam int NREG = NE * 16;
  localparam logic [3:0] F_BLO = 4'd0, F_BHI = 4'd1, F_RLO = 4'd2, F_RHI = 4'd3,
                         F_WLO = 4'd4, F_WHI = 4'd5, F_DBC = 4'd6, F_DBO = 4'd7,
                         F_SZ  = 4'd8;

  function automatic logic [31:0] base_of(input int e);
    if (VARIANT == 0) return (e == 0) ? 32'h4980 : 32'h5180;
    case (e)
      0: return 32'h4980;
      1: return 32'h6180;
      default: return 32'h78000 + 32'(e - 2) * 32'h1000;
    endcase
  endfunction

  logic [31:0] a32, off;
  logic        hit;
  logic [2:0]  eng;
  logic [9:0]  idx;
  logic        known, q;
  logic [3:0]  fld;

  assign a32 = 32'(wr_addr);

  always_comb begin
    hit = 1'b0;
    eng = '0;
    off = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (a32 >= base_of(e) && a32 < base_of(e) + WIN) begin
        hit = 1'b1;
        eng = 3'(e);
        off = a32 - base_of(e);
      end
    end
  end

  assign idx = off[11:2];

  always_comb begin
    known = 1'b1;
    q = 1'b0;
    fld = F_BLO;
    case (idx)
      10'h080: fld = F_SZ;
      10'h081: fld = F_BLO;
      10'h082: fld = F_BHI;
      10'h088: fld = F_RHI;
      10'h089: fld = F_RLO;
      10'h092: fld = F_DBC;
      10'h0AB: fld = F_DBO;
      10'h0B2: fld = F_WLO;
      10'h0B3: fld = F_WHI;
      default: begin
        q = 1'b1;
        if (VARIANT == 0) begin
          case (idx)
            10'h0E1: fld = F_BLO;
            10'h0E9: fld = F_RLO;
            10'h0E8: fld = F_RHI;
            10'h0F2: fld = F_DBC;
            10'h10B: fld = F_DBO;
            10'h0E0: fld = F_SZ;
            10'h113: fld = F_WLO;
            default: known = 1'b0;
          endcase
        end else begin
          case (idx)
            10'h0D9: fld = F_BLO;
            10'h0E1: fld = F_RLO;
            10'h0E0: fld = F_RHI;
            10'h0EA: fld = F_DBC;
            10'h0D8: fld = F_DBO;
            10'h10B: fld = F_WLO;
            default: known = 1'b0;
          endcase
        end
      end
    endcase
  end

  logic [31:0] rf [NREG];
  logic [6:0]  lg [NE*2];
  logic        we, sz_ok;
  logic [5:0]  sz;
  int          wi, qi;

  assign we    = wr_valid && hit && known;
  assign sz    = wr_data[6:1];
  assign sz_ok = (sz >= 6'd6) && (sz <= 6'd62);
  assign wi    = int'(eng) * 16 + int'(q) * 8 + int'(fld[2:0]);
  assign qi    = int'(eng) * 2 + int'(q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      for (int i = 0; i < NE*2; i++) lg[i] <= '0;
      size_err  <= 1'b0;
      db_valid  <= 1'b0;
      db_offset <= '0;
      db_engine <= '0;
      db_queue  <= 1'b0;
    end else begin
      db_valid <= 1'b0;
      if (we) begin
        if (fld == F_SZ) begin
          if (sz_ok) lg[qi] <= 7'(sz) + 7'd2;
          else size_err <= 1'b1;
        end else begin
          rf[wi] <= wr_data;
        end
        if (fld == F_DBO && rf[int'(eng)*16 + int'(q)*8 + int'(F_DBC)][28]) begin
          db_valid  <= 1'b1;
          db_offset <= wr_data;
          db_engine <= eng;
          db_queue  <= q;
        end
      end
    end
  end

  assign fb_valid = wr_valid && !hit;
  assign fb_addr  = wr_addr;
  assign fb_data  = wr_data;

  logic       rd_ok;
  logic [6:0] lg_sel;
  assign rd_ok  = int'(rd_engine) < NE;
  assign lg_sel = rd_ok ? lg[int'(rd_engine)*2 + int'(rd_queue)] : 7'd0;

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      if (rd_sel == F_SZ) rd_data = 32'(lg_sel);
      else if (rd_sel < 4'd8) rd_data = rf[int'(rd_engine)*16 + int'(rd_queue)*8 + int'(rd_sel[2:0])];
    end
  end

  assign rd_len = (lg_sel == 7'd0) ? 65'd0 : (65'd1 << lg_sel);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);

  // R6
  miss_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |=> !db_valid);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_valid) |-> $past(wr_valid) && !$past(fb_valid));

  // R9
  pulse_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> int'(db_engine) < NE);

  // R6
  fb_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> wr_valid);
endmodule

// File: tb/sim_dma_reg_decoder.sv
`timescale 1ns/1ps
module sim_dma_reg_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  r0_eng = '0, r1_eng = '0;
  logic        r0_q = 1'b0, r1_q = 1'b0;
  logic [3:0]  r0_sel = '0, r1_sel = '0;

  logic        fb0_v, fb1_v, err0, err1, db0_v, db1_v, db0_q, db1_q;
  logic [19:0] fb0_a, fb1_a;
  logic [31:0] fb0_d, fb1_d, rd0, rd1, db0_o, db1_o;
  logic [64:0] len0, len1;
  logic [2:0]  db0_e, db1_e;

  dma_reg_decoder #(.VARIANT(1), .AW(20)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .fb_valid(fb0_v), .fb_addr(fb0_a), .fb_data(fb0_d),
    .rd_engine(r0_eng), .rd_queue(r0_q), .rd_sel(r0_sel), .rd_data(rd0), .rd_len(len0),
    .size_err(err0), .db_valid(db0_v), .db_offset(db0_o), .db_engine(db0_e), .db_queue(db0_q));

  dma_reg_decoder #(.VARIANT(0), .AW(20)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .fb_valid(fb1_v), .fb_addr(fb1_a), .fb_data(fb1_d),
    .rd_engine(r1_eng), .rd_queue(r1_q), .rd_sel(r1_sel), .rd_data(rd1), .rd_len(len1),
    .size_err(err1), .db_valid(db1_v), .db_offset(db1_o), .db_engine(db1_e), .db_queue(db1_q));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
  endtask

  task automatic rd_u0(input logic [2:0] e, input logic q, input logic [3:0] s);
    r0_eng = e; r0_q = q; r0_sel = s; #1;
  endtask

  // {addr[19:0], data[31:0], eng[2:0], queue, sel[3:0], expect[31:0]} for u0
  localparam logic [91:0] VEC [8] = '{
    {20'h04B84, 32'h12345000, 3'd0, 1'b0, 4'd0, 32'h12345000},  // R3 base low, engine 0
    {20'h78224, 32'hAAAA0001, 3'd2, 1'b0, 4'd2, 32'hAAAA0001},  // R2 R3 rptr low, engine 2
    {20'h7D2CC, 32'h00000055, 3'd7, 1'b0, 4'd5, 32'h00000055},  // R2 wptr high, last engine
    {20'h064E4, 32'h0000BEEF, 3'd1, 1'b1, 4'd0, 32'h0000BEEF},  // R4 secondary base low
    {20'h79380, 32'h00000077, 3'd3, 1'b1, 4'd3, 32'h00000077},  // R4 secondary rptr high
    {20'h7A42C, 32'h00000009, 3'd4, 1'b1, 4'd4, 32'h00000009},  // R4 secondary wptr low
    {20'h7B208, 32'h0000C0DE, 3'd5, 1'b0, 4'd1, 32'h0000C0DE},  // R3 base high
    {20'h7C200, 32'h00000014, 3'd6, 1'b0, 4'd8, 32'h0000000C}   // R7 size field 10
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd_u0(3'd0, 1'b0, 4'd0);
    chk("R1 reg", rd0, 0);
    chk("R1 len", len0, 0);
    chk("R1 err", err0, 0);
    chk("R1 db", db0_v, 0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][91:72], VEC[i][71:40]);
      rd_u0(VEC[i][39:37], VEC[i][36], VEC[i][35:32]);
      chk($sformatf("R2/R3/R4/R7 vector %0d", i), rd0, VEC[i][31:0]);
    end

    // R7 byte length for field 10
    rd_u0(3'd6, 1'b0, 4'd8);
    chk("R7 len", len0, 65'd4096);

    // R6 miss: same-cycle forward
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 20'h01000; wr_data = 32'hF00D;
    #1;
    chk("R6 fb_valid", fb0_v, 1);
    chk("R6 fb_addr", fb0_a, 20'h01000);
    chk("R6 fb_data", fb0_d, 32'hF00D);
    @(negedge clk);
    wr_valid = 1'b0;
    // R2 window edges for eight-engine copy
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 20'h05980; #1;
    chk("R2 above window end", fb0_v, 1);
    wr_addr = 20'h0597C; #1;
    chk("R2 last word in window", fb0_v, 0);
    wr_valid = 1'b0;

    // R5: 0x5180 is engine 1 base in u1, unmapped index in u0's engine 0
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 20'h05180; wr_data = 32'h1; #1;
    chk("R5 no fallback", fb0_v, 0);
    chk("R2 two-engine window hit", fb1_v, 0);
    @(negedge clk);
    wr_valid = 1'b0; #1;
    chk("R5 no pulse", db0_v, 0);
    rd_u0(3'd0, 1'b0, 4'd0);
    chk("R5 unchanged", rd0, 32'h12345000);

    // R4 variant split: index 0xE0 is size in u1, rptr high in u0
    wr(20'h04D00, 32'h00000028);
    r1_eng = 3'd0; r1_q = 1'b1; r1_sel = 4'd8; #1;
    chk("R4 two-engine secondary size", rd1, 22);
    rd_u0(3'd0, 1'b1, 4'd3);
    chk("R4 eight-engine secondary rptr high", rd0, 32'h28);

    // R8 illegal size, then legal maximum
    wr(20'h7C200, 32'h0000000A);
    rd_u0(3'd6, 1'b0, 4'd8);
    chk("R8 err set", err0, 1);
    chk("R8 size kept", rd0, 12);
    wr(20'h7C200, 32'h0000007C);
    rd_u0(3'd6, 1'b0, 4'd8);
    chk("R7 field 62", rd0, 64);
    chk("R7 len max", len0, 65'h1_0000_0000_0000_0000);
    chk("R8 sticky", err0, 1);
    wr(20'h7C200, 32'h0000007E);
    chk("R8 field 63 keeps size", rd0, 64);

    // R9 primary doorbell
    wr(20'h78248, 32'h10000000);
    chk("R9 ctrl write no pulse", db0_v, 0);
    wr(20'h782AC, 32'h000001C0);
    chk("R9 pulse", db0_v, 1);
    chk("R9 offset", db0_o, 32'h1C0);
    chk("R9 engine", db0_e, 2);
    chk("R9 queue", db0_q, 0);
    @(negedge clk); #1;
    chk("R9 one cycle", db0_v, 0);

    // R9 secondary doorbell, eight-engine map
    wr(20'h7D3A8, 32'h10000000);
    wr(20'h7D360, 32'h000002F0);
    chk("R9 sec pulse", db0_v, 1);
    chk("R9 sec engine", db0_e, 7);
    chk("R9 sec queue", db0_q, 1);
    chk("R9 sec offset", db0_o, 32'h2F0);

    // R10 disabled doorbell
    wr(20'h792AC, 32'h00000044);
    chk("R10 no pulse", db0_v, 0);
    rd_u0(3'd3, 1'b0, 4'd7);
    chk("R10 offset stored", rd0, 32'h44);

    // R11 update only after the edge
    rd_u0(3'd0, 1'b0, 4'd4);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 20'h04C48; wr_data = 32'h99; #1;
    chk("R11 before edge", rd0, 0);
    @(negedge clk);
    wr_valid = 1'b0; #1;
    chk("R11 after edge", rd0, 32'h99);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule